// File: doc/BRIEF.md
# Dual-Threshold Gated Pulse Window Counter

This block counts pulses on two asynchronous comparator levels during a hardware-timed gate and reports how many pulses fell inside an amplitude band. One comparator trips at a lower threshold and the other at an upper threshold. A pulse tall enough to cross the lower threshold but not the upper one shows up on the lower channel only. The in-band result is therefore the lower count minus the upper count. Both channel counters are cleared and enabled by one clock edge, so both see exactly the same time window. The results are latched only after the gate has closed and counting has stopped.

A one-cycle start command arms a window. A threshold-updated strobe tells the block that the analog thresholds were just changed. The block then clears everything, waits a settling delay and starts a fresh window on its own. In continuous mode a new window opens on the cycle after each capture. Each channel counter is a base counter with extension bits that take its wraps, and it never reloads on terminal count.

The controller has four states. In IDLE it waits for a command. SETTLE covers the settling delay after a threshold update. COUNT is the open gate. CAPTURE is the one-cycle latch of the results. The transitions are:
- IDLE→COUNT on start.
- any state→SETTLE on a threshold update.
- SETTLE→COUNT when the settle timer expires.
- COUNT→COUNT on a restart by start.
- COUNT→CAPTURE when the gate timer expires.
- CAPTURE→COUNT on continuous mode or start.
- CAPTURE→IDLE otherwise.

Top module: `pulse_window_counter`

## Requirements
- R1: After reset, all count outputs are zero and `done_o` and `anomaly_o` are low.
- R2: A start command sampled in IDLE clears both channel counters on the same edge. The gate stays open for exactly GATE_CYCLES cycles, and `done_o` is high after the edge that falls GATE_CYCLES+1 edges after the edge that sampled the start.
- R3: Each comparator input passes through a two-flip-flop synchronizer. Each rising edge of the synchronized level counts once, so a level held high for many cycles adds exactly one.
- R4: Pulses that arrive while no gate is open are not counted.
- R5: Each channel total is {extension, base}. The BASE_W-bit base wraps from all-ones to zero and carries into the EXT_W extension bits, with no reload. A total above 2^BASE_W-1 is therefore reported exactly.
- R6: The outputs `lo_count_o`, `hi_count_o` and `window_o` change only at capture and hold their value until the next capture.
- R7: `window_o` equals the lower count minus the upper count when the lower count is not smaller.
- R8: When the upper count exceeds the lower count, `window_o` is zero and `anomaly_o` is set. `anomaly_o` then stays high until reset.
- R9: `done_o` is high for exactly one cycle per capture.
- R10: With `continuous_i` high, the next `done_o` comes GATE_CYCLES+1 cycles after the previous one, and its counts start from zero. With `continuous_i` low, the block returns to IDLE and produces no further `done_o`.
- R11: A start command during an open gate discards the partial counts and restarts the full gate from that edge.
- R12: A threshold-update strobe clears both counters and waits SETTLE_CYCLES cycles before the gate opens. `done_o` is high after the edge that falls SETTLE_CYCLES+GATE_CYCLES+1 edges after the edge that sampled the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_lo_i | input | 1 | Asynchronous lower-threshold comparator level |
| cmp_hi_i | input | 1 | Asynchronous upper-threshold comparator level |
| start_i | input | 1 | One-cycle start / restart command |
| continuous_i | input | 1 | Re-arm automatically after each capture |
| thr_upd_i | input | 1 | One-cycle strobe: thresholds were changed |
| lo_count_o | output | BASE_W+EXT_W | Latched lower-threshold pulse count |
| hi_count_o | output | BASE_W+EXT_W | Latched upper-threshold pulse count |
| window_o | output | BASE_W+EXT_W | Latched lower-minus-upper result, saturated at zero |
| done_o | output | 1 | One-cycle pulse when results are latched |
| anomaly_o | output | 1 | Sticky flag: upper count exceeded lower count |

## Verification
The assertions assume the following about the inputs. The commands `start_i` and `thr_upd_i` are single-cycle strobes. The comparator levels can change at any time, but each level stays stable for at least two clock cycles, which is what lets the synchronizer pass every edge through. The stimulus holds every comparator pulse high and low for two cycles or more. It places counted pulses several cycles after the gate opens and well before it closes, so the sync latency never moves a pulse across a gate boundary. Commands are only issued on falling clock edges for one cycle.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        PWC_IDLE    = 2'd0,
        PWC_SETTLE  = 2'd1,
        PWC_COUNT   = 2'd2,
        PWC_CAPTURE = 2'd3
    } pwc_state_e;

endpackage

// File: rtl/pwc_sync_edge.sv
module pwc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/pwc_chan_counter.sv
module pwc_chan_counter #(
    parameter int BASE_W = 16,
    parameter int EXT_W  = 16,
    localparam int TOT_W = BASE_W + EXT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [TOT_W-1:0] count_o,
    output logic             wrap_o
);

    logic [BASE_W-1:0] base_q;
    logic [EXT_W-1:0]  ext_q;
    logic              base_full;

    assign base_full = &base_q;
    assign wrap_o    = inc_i & base_full & ~clr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ext_q  <= '0;
        end else if (clr_i) begin
            base_q <= '0;
            ext_q  <= '0;
        end else if (inc_i) begin
            base_q <= base_q + BASE_W'(1);
            if (base_full) ext_q <= ext_q + EXT_W'(1);
        end
    end

    assign count_o = {ext_q, base_q};

endmodule

// File: rtl/pwc_gate_timer.sv
module pwc_gate_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         run_i,
    output logic         expired_o
);

    logic [W-1:0] left_q;

    assign expired_o = (left_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     left_q <= '0;
        else if (load_i)                left_q <= load_val_i;
        else if (run_i && !expired_o)   left_q <= left_q - W'(1);
    end

endmodule

// File: rtl/pulse_window_counter.sv
module pulse_window_counter
    import pwc_pkg::*;
#(
    parameter int BASE_W        = 16,
    parameter int EXT_W         = 16,
    parameter int GATE_CYCLES   = 1_250_000_000,
    parameter int SETTLE_CYCLES = 3125,
    localparam int TOT_W   = BASE_W + EXT_W,
    localparam int TMR_MAX = (GATE_CYCLES > SETTLE_CYCLES) ? GATE_CYCLES : SETTLE_CYCLES,
    localparam int TMR_W   = $clog2(TMR_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_lo_i,
    input  logic             cmp_hi_i,
    input  logic             start_i,
    input  logic             continuous_i,
    input  logic             thr_upd_i,
    output logic [TOT_W-1:0] lo_count_o,
    output logic [TOT_W-1:0] hi_count_o,
    output logic [TOT_W-1:0] window_o,
    output logic             done_o,
    output logic             anomaly_o
);

    localparam logic [TMR_W-1:0] GATE_LOAD   = TMR_W'(GATE_CYCLES - 1);
    localparam logic [TMR_W-1:0] SETTLE_LOAD = TMR_W'(SETTLE_CYCLES - 1);

    pwc_state_e state_q, state_n;

    logic             lo_rise, hi_rise;
    logic             cnt_clr, cnt_en;
    logic             tmr_load, tmr_run, tmr_expired;
    logic [TMR_W-1:0] tmr_val;
    logic [TOT_W-1:0] lo_cnt, hi_cnt;
    logic             lo_wrap, hi_wrap;
    logic [TOT_W-1:0] diff;
    logic             upper_excess;

    // Input conditioning: synchronizer and rising-edge pick per channel
    pwc_sync_edge #(.STAGES(2)) u_sync_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(cmp_lo_i),
        .rise_o (lo_rise)
    );

    pwc_sync_edge #(.STAGES(2)) u_sync_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(cmp_hi_i),
        .rise_o (hi_rise)
    );

    // Channel counters share clear and enable
    pwc_chan_counter #(.BASE_W(BASE_W), .EXT_W(EXT_W)) u_cnt_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_en & lo_rise),
        .count_o(lo_cnt),
        .wrap_o (lo_wrap)
    );

    pwc_chan_counter #(.BASE_W(BASE_W), .EXT_W(EXT_W)) u_cnt_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_en & hi_rise),
        .count_o(hi_cnt),
        .wrap_o (hi_wrap)
    );

    // One timer serves both settle delay and gate
    pwc_gate_timer #(.W(TMR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .run_i     (tmr_run),
        .expired_o (tmr_expired)
    );

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            PWC_IDLE: begin
                if (thr_upd_i)    state_n = PWC_SETTLE;
                else if (start_i) state_n = PWC_COUNT;
            end
            PWC_SETTLE: begin
                if (thr_upd_i)        state_n = PWC_SETTLE;
                else if (tmr_expired) state_n = PWC_COUNT;
            end
            PWC_COUNT: begin
                if (thr_upd_i)        state_n = PWC_SETTLE;
                else if (start_i)     state_n = PWC_COUNT;
                else if (tmr_expired) state_n = PWC_CAPTURE;
            end
            PWC_CAPTURE: begin
                if (thr_upd_i)                    state_n = PWC_SETTLE;
                else if (continuous_i || start_i) state_n = PWC_COUNT;
                else                              state_n = PWC_IDLE;
            end
            default: state_n = PWC_IDLE;
        endcase
    end

    // Control decode for counters and timer
    always_comb begin
        cnt_clr = thr_upd_i ||
                  ((state_n == PWC_COUNT) && ((state_q != PWC_COUNT) || start_i));
        cnt_en  = (state_q == PWC_COUNT) && !cnt_clr;
        tmr_run = (state_q == PWC_SETTLE) || (state_q == PWC_COUNT);
        tmr_load = cnt_clr;
        tmr_val  = thr_upd_i ? SETTLE_LOAD : GATE_LOAD;
    end

    // Result arithmetic
    assign upper_excess = (hi_cnt > lo_cnt);
    assign diff         = upper_excess ? '0 : (lo_cnt - hi_cnt);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWC_IDLE;
        else        state_q <= state_n;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_count_o <= '0;
            hi_count_o <= '0;
            window_o   <= '0;
            done_o     <= 1'b0;
            anomaly_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (state_q == PWC_CAPTURE) begin
                lo_count_o <= lo_cnt;
                hi_count_o <= hi_cnt;
                window_o   <= diff;
                done_o     <= 1'b1;
                if (upper_excess) anomaly_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
    parameter int TOT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       state_q,
    input logic             cnt_clr,
    input logic             cnt_en,
    input logic [TOT_W-1:0] lo_cnt,
    input logic [TOT_W-1:0] hi_cnt,
    input logic [TOT_W-1:0] lo_count_o,
    input logic [TOT_W-1:0] hi_count_o,
    input logic [TOT_W-1:0] window_o,
    input logic             done_o,
    input logic             anomaly_o
);

    localparam logic [1:0] ST_CAPTURE = 2'd3;

    p_common_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (lo_cnt == '0) && (hi_cnt == '0));

    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> ((lo_cnt == $past(lo_cnt)) || (lo_cnt == $past(lo_cnt) + 1'b1)));

    p_no_count_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cnt_clr) |=> ($stable(lo_cnt) && $stable(hi_cnt)));

    p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_CAPTURE) |=> ($stable(lo_count_o) && $stable(hi_count_o) && $stable(window_o)));

    p_window_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        window_o <= lo_count_o);

    p_anomaly_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        anomaly_o |=> anomaly_o);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(state_q) == ST_CAPTURE));

endmodule

bind pulse_window_counter pwc_checker #(.TOT_W(TOT_W)) u_pwc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .cnt_clr   (cnt_clr),
    .cnt_en    (cnt_en),
    .lo_cnt    (lo_cnt),
    .hi_cnt    (hi_cnt),
    .lo_count_o(lo_count_o),
    .hi_count_o(hi_count_o),
    .window_o  (window_o),
    .done_o    (done_o),
    .anomaly_o (anomaly_o)
);

// File: tb/pulse_window_counter_tb_top.sv
`timescale 1ns/1ps
module pulse_window_counter_tb_top;

    localparam int BASE_W = 8;
    localparam int EXT_W  = 4;
    localparam int TOT_W  = BASE_W + EXT_W;
    localparam int GATE   = 1200;
    localparam int SETTLE = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmp_lo_i = 1'b0, cmp_hi_i = 1'b0;
    logic             start_i = 1'b0, continuous_i = 1'b0, thr_upd_i = 1'b0;
    logic [TOT_W-1:0] lo_count_o, hi_count_o, window_o;
    logic             done_o, anomaly_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pulse_window_counter #(
        .BASE_W(BASE_W), .EXT_W(EXT_W),
        .GATE_CYCLES(GATE), .SETTLE_CYCLES(SETTLE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmp_lo_i(cmp_lo_i), .cmp_hi_i(cmp_hi_i),
        .start_i(start_i), .continuous_i(continuous_i), .thr_upd_i(thr_upd_i),
        .lo_count_o(lo_count_o), .hi_count_o(hi_count_o), .window_o(window_o),
        .done_o(done_o), .anomaly_o(anomaly_o)
    );

    function automatic int exp_window(int lo, int hi);
        return (lo >= hi) ? lo - hi : 0;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe_start(output int s);
        start_i = 1'b1; s = cyc;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic strobe_thr(output int s);
        thr_upd_i = 1'b1; s = cyc;
        @(negedge clk); thr_upd_i = 1'b0;
    endtask

    task automatic pulses(int nlo, int nhi);
        int m = (nlo > nhi) ? nlo : nhi;
        for (int i = 0; i < m; i++) begin
            cmp_lo_i = (i < nlo); cmp_hi_i = (i < nhi);
            idle(2);
            cmp_lo_i = 1'b0; cmp_hi_i = 1'b0;
            idle(2);
        end
    endtask

    task automatic wait_done(output int at);
        at = -1;
        for (int i = 0; i < 5000; i++) begin
            if (done_o) begin at = cyc; break; end
            @(negedge clk);
        end
        if (at < 0) check("R9 done timeout", 0, 1);
    endtask

    task automatic check_result(string tag, int lo, int hi);
        check({tag, " lo"}, int'(lo_count_o), lo);
        check({tag, " hi"}, int'(hi_count_o), hi);
        check({tag, " window"}, int'(window_o), exp_window(lo, hi));
    endtask

    task automatic run_window(string tag, int nlo, int nhi);
        int s, d;
        strobe_start(s);
        idle(5);
        pulses(nlo, nhi);
        wait_done(d);
        check({tag, " R2 gate length"}, d - s, GATE + 2);
        check_result(tag, nlo, nhi);
        @(negedge clk);
        check({tag, " R9 done one cycle"}, int'(done_o), 0);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (cyc > 150000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<=150000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int s, d, d2, lo_prev;
        void'($urandom(32'd20240));
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check("R1 lo", int'(lo_count_o), 0);
        check("R1 window", int'(window_o), 0);
        check("R1 done", int'(done_o), 0);
        check("R1 anomaly", int'(anomaly_o), 0);

        // R7 basic window
        run_window("R7 basic", 12, 5);

        // R4 / R6: pulses while idle do not change latched outputs
        pulses(7, 3);
        idle(5);
        check("R6 hold lo", int'(lo_count_o), 12);
        check("R4 no done idle", int'(done_o), 0);
        run_window("R4 empty window", 0, 0);

        // R3 long level counts once
        strobe_start(s);
        idle(5);
        cmp_lo_i = 1'b1; idle(60); cmp_lo_i = 1'b0;
        wait_done(d);
        check("R3 level counts once", int'(lo_count_o), 1);

        // R5 base wrap into extension (2^BASE_W = 256)
        run_window("R5 rollover", 290, 20);

        // R8 upper exceeds lower
        run_window("R8 excess", 3, 9);
        check("R8 anomaly set", int'(anomaly_o), 1);
        run_window("R8 sticky", 6, 1);
        check("R8 anomaly sticky", int'(anomaly_o), 1);

        // R11 restart discards partial counts
        strobe_start(s);
        idle(5);
        pulses(10, 4);
        strobe_start(s);
        idle(5);
        pulses(3, 1);
        wait_done(d);
        check("R11 restart length", d - s, GATE + 2);
        check_result("R11", 3, 1);

        // R12 threshold update with settle
        strobe_start(s);
        idle(5);
        pulses(8, 2);
        strobe_thr(s);
        idle(SETTLE + 5);
        pulses(4, 1);
        wait_done(d);
        check("R12 settle+gate length", d - s, SETTLE + GATE + 2);
        check_result("R12", 4, 1);

        // R10 continuous re-arm
        continuous_i = 1'b1;
        strobe_start(s);
        idle(5);
        pulses(9, 2);
        wait_done(d);
        check_result("R10 first", 9, 2);
        @(negedge clk);
        idle(5);
        pulses(5, 2);
        wait_done(d2);
        check("R10 spacing", d2 - d, GATE + 1);
        check_result("R10 second", 5, 2);
        continuous_i = 1'b0;
        @(negedge clk);
        wait_done(d);
        check_result("R10 third empty", 0, 0);
        @(negedge clk);
        lo_prev = int'(lo_count_o);
        d2 = 0;
        for (int i = 0; i < GATE + 20; i++) begin
            @(negedge clk);
            if (done_o) d2++;
        end
        check("R10 stop when not continuous", d2, 0);
        check("R10 hold", int'(lo_count_o), lo_prev);

        // Random windows
        for (int k = 0; k < 8; k++) begin
            int nlo, nhi;
            nlo = int'($urandom_range(0, 250));
            nhi = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 250))
                                              : int'($urandom_range(0, nlo));
            run_window("R7 random", nlo, nhi);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule